// File: doc/BRIEF.md
# AHB crossbar routing datapath

This block is the steering datapath of a bus matrix with several AHB-style managers and several subordinate ports. Address decoding and arbitration sit outside it: each manager port supplies the index of the subordinate it is addressing, and each subordinate port supplies a grant (a manager index plus a valid bit). From these the block forwards the granted manager's address, control and write data to each subordinate, and returns each subordinate's read data, ready and response to the manager that issued the transfer.

Routing follows the two-phase pipeline. Forward selection happens while the address is offered. Return selection happens in the data phase. It is steered by a per-manager register that holds the decoded target from the address phase until the data phase completes. A connectivity mask removes chosen manager-to-subordinate paths at elaboration. A parameter adds a register stage on the forward path. That stage delays whole transfers by one cycle, and the address and data phases still stay paired.

Top module: `ahb_xbar_route`

## Requirements
- R1: When subordinate s grants manager m (`s_gnt_vld[s]`=1, `s_gnt[s]`=m), m has ready high, an active transfer (`m_htrans[m][1]`=1) and target index s, then `s_hsel[s]`=1 and s's address, direction, size and transfer type equal m's.
- R2: The write data at each subordinate comes from the manager that owns that subordinate's current data phase, taken from the grant of the preceding address phase.
- R3: A manager's data-phase target register loads only when that manager's `m_hready` is high. A change of `m_tgt` during a wait state does not change which subordinate answers.
- R4: In the data phase, a manager's `m_hready`, `m_hresp` and `m_hrdata` equal those of the subordinate it addressed. Read data reaches only the issuing manager.
- R5: With `REG_FWD`=0, the forward path is combinational. A transfer's data phase lasts the subordinate's wait states plus one cycle.
- R6: With `REG_FWD`=1, the subordinate sees the address one cycle after the manager offers it. The manager's data phase lasts exactly one cycle longer than in R5.
- R7: Transfers on disjoint manager/subordinate pairs run in the same cycles and do not disturb each other.
- R8: `CONN` bit m*NS+s cleared removes the path from manager m to subordinate s. A transfer on it is never forwarded.
- R9: A manager with no data phase, or whose transfer targeted a removed path, sees `m_hready`=1, `m_hresp`=0 (OKAY; 1 means ERROR) and zero read data.
- R10: After reset every `m_hready` is 1, every `m_hresp` is 0, all read data is zero and no `s_hsel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_tgt | input | NM*SW | Decoded subordinate index per manager |
| m_htrans | input | NM*2 | Transfer type per manager (bit 1 = active) |
| m_haddr | input | NM*AW | Address per manager |
| m_hwrite | input | NM | Write direction per manager |
| m_hsize | input | NM*3 | Transfer size per manager |
| m_hwdata | input | NM*DW | Write data per manager |
| m_hready | output | NM | Ready returned to each manager |
| m_hresp | output | NM | Response returned to each manager |
| m_hrdata | output | NM*DW | Read data returned to each manager |
| s_gnt | input | NS*MW | Granted manager index per subordinate |
| s_gnt_vld | input | NS | Grant valid per subordinate |
| s_hsel | output | NS | Select per subordinate |
| s_htrans | output | NS*2 | Forwarded transfer type |
| s_haddr | output | NS*AW | Forwarded address |
| s_hwrite | output | NS | Forwarded direction |
| s_hsize | output | NS*3 | Forwarded size |
| s_hwdata | output | NS*DW | Forwarded write data |
| s_hreadyout | input | NS | Ready from each subordinate |
| s_hresp | input | NS | Response from each subordinate |
| s_hrdata | input | NS*DW | Read data from each subordinate |

## Verification
Forward signals are due in the cycle the address is offered when `REG_FWD`=0, and one cycle later when it is 1. The bench samples the subordinate side after the negative edge of exactly that cycle. Return results are due on the data-phase cycle where `m_hready` is high. The bench counts data-phase cycles from the cycle after the address and compares the count with the subordinate wait states plus one, plus one more in the registered instance. Read data and response are sampled in that completing cycle. Write data is checked one edge later in the subordinate model's capture register.

// File: rtl/ahb_xbar_route.sv
module ahb_xbar_route #(
  parameter int NM = 2,
  parameter int NS = 2,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit REG_FWD = 1'b0,
  parameter logic [NM*NS-1:0] CONN = '1,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NM-1:0][SW-1:0]   m_tgt,
  input  logic [NM-1:0][1:0]      m_htrans,
  input  logic [NM-1:0][AW-1:0]   m_haddr,
  input  logic [NM-1:0]           m_hwrite,
  input  logic [NM-1:0][2:0]      m_hsize,
  input  logic [NM-1:0][DW-1:0]   m_hwdata,
  output logic [NM-1:0]           m_hready,
  output logic [NM-1:0]           m_hresp,
  output logic [NM-1:0][DW-1:0]   m_hrdata,
  input  logic [NS-1:0][MW-1:0]   s_gnt,
  input  logic [NS-1:0]           s_gnt_vld,
  output logic [NS-1:0]           s_hsel,
  output logic [NS-1:0][1:0]      s_htrans,
  output logic [NS-1:0][AW-1:0]   s_haddr,
  output logic [NS-1:0]           s_hwrite,
  output logic [NS-1:0][2:0]      s_hsize,
  output logic [NS-1:0][DW-1:0]   s_hwdata,
  input  logic [NS-1:0]           s_hreadyout,
  input  logic [NS-1:0]           s_hresp,
  input  logic [NS-1:0][DW-1:0]   s_hrdata
);

  logic [NM-1:0]          dp_v, pend, conn_t;
  logic [NM-1:0][SW-1:0]  dp_t;
  logic [NS-1:0][NM-1:0]  hit;
  logic [NM-1:0][NS-1:0]  rsel;
  logic [NS-1:0][MW-1:0]  dp_own, own_q;

  logic [NS-1:0]          f_sel, f_wr;
  logic [NS-1:0][1:0]     f_tr;
  logic [NS-1:0][AW-1:0]  f_ad;
  logic [NS-1:0][2:0]     f_sz;
  logic [NS-1:0][MW-1:0]  f_own;

  for (genvar m = 0; m < NM; m++) begin : g_m
    for (genvar s = 0; s < NS; s++) begin : g_s
      if (CONN[m*NS+s]) begin : g_path
        assign hit[s][m]  = s_gnt_vld[s] && s_gnt[s] == MW'(m) && m_tgt[m] == SW'(s)
                            && m_htrans[m][1] && m_hready[m];
        assign rsel[m][s] = dp_v[m] && !pend[m] && dp_t[m] == SW'(s);
      end else begin : g_cut
        assign hit[s][m]  = 1'b0;
        assign rsel[m][s] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      conn_t[m] = 1'b0;
      for (int s = 0; s < NS; s++)
        if (m_tgt[m] == SW'(s)) conn_t[m] = CONN[m*NS+s];
    end
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      f_sel[s] = |hit[s];
      f_tr[s]  = '0;
      f_ad[s]  = '0;
      f_wr[s]  = 1'b0;
      f_sz[s]  = '0;
      f_own[s] = '0;
      for (int m = 0; m < NM; m++) begin
        if (hit[s][m]) begin
          f_tr[s]  = f_tr[s]  | m_htrans[m];
          f_ad[s]  = f_ad[s]  | m_haddr[m];
          f_wr[s]  = f_wr[s]  | m_hwrite[m];
          f_sz[s]  = f_sz[s]  | m_hsize[m];
          f_own[s] = f_own[s] | MW'(m);
        end
      end
    end
  end

  if (REG_FWD) begin : g_fwd_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_hsel   <= '0;
        s_htrans <= '0;
        s_haddr  <= '0;
        s_hwrite <= '0;
        s_hsize  <= '0;
        own_q    <= '0;
      end else begin
        s_hsel   <= f_sel;
        s_htrans <= f_tr;
        s_haddr  <= f_ad;
        s_hwrite <= f_wr;
        s_hsize  <= f_sz;
        own_q    <= f_own;
      end
    end
  end else begin : g_fwd_comb
    assign s_hsel   = f_sel;
    assign s_htrans = f_tr;
    assign s_haddr  = f_ad;
    assign s_hwrite = f_wr;
    assign s_hsize  = f_sz;
    assign own_q    = f_own;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dp_own <= '0;
    else
      for (int s = 0; s < NS; s++)
        if (s_hsel[s] && s_htrans[s][1] && s_hreadyout[s]) dp_own[s] <= own_q[s];
  end

  for (genvar s = 0; s < NS; s++) begin : g_wd
    assign s_hwdata[s] = m_hwdata[dp_own[s]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_v <= '0;
      dp_t <= '0;
      pend <= '0;
    end else begin
      for (int m = 0; m < NM; m++) begin
        if (m_hready[m]) begin
          dp_v[m] <= m_htrans[m][1] && conn_t[m];
          dp_t[m] <= m_tgt[m];
        end
        pend[m] <= REG_FWD && m_hready[m] && m_htrans[m][1] && conn_t[m];
      end
    end
  end

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      m_hready[m] = !pend[m];
      m_hresp[m]  = 1'b0;
      m_hrdata[m] = '0;
      for (int s = 0; s < NS; s++) begin
        if (rsel[m][s]) begin
          m_hready[m] = s_hreadyout[s];
          m_hresp[m]  = s_hresp[s];
          m_hrdata[m] = s_hrdata[s];
        end
      end
    end
  end

endmodule

module ahb_xbar_route_chk #(
  parameter int NM = 2,
  parameter int NS = 2,
  parameter int DW = 32,
  parameter int SW = 1,
  parameter bit REG_FWD = 1'b0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NM-1:0][1:0]    m_htrans,
  input logic [NM-1:0]         m_hready,
  input logic [NM-1:0]         m_hresp,
  input logic [NM-1:0][DW-1:0] m_hrdata,
  input logic [NS-1:0]         s_hreadyout,
  input logic [NM-1:0]         dp_v,
  input logic [NM-1:0][SW-1:0] dp_t,
  input logic [NM-1:0]         pend
);
  for (genvar m = 0; m < NM; m++) begin : g_m
    a_r3_hold_target: assert property (@(posedge clk) disable iff (!rst_n)
      !m_hready[m] |=> $stable(dp_t[m]) && $stable(dp_v[m]));

    a_r4_return_ready: assert property (@(posedge clk) disable iff (!rst_n)
      dp_v[m] && !pend[m] |-> m_hready[m] == s_hreadyout[dp_t[m]]);

    a_r9_idle_okay: assert property (@(posedge clk) disable iff (!rst_n)
      !dp_v[m] && !pend[m] |-> m_hready[m] && !m_hresp[m] && m_hrdata[m] == '0);

    a_r9_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
      $past(m_hready[m]) && !$past(m_htrans[m][1]) |-> m_hready[m]);

    if (REG_FWD) begin : g_reg
      a_r6_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        $past(m_hready[m] && m_htrans[m][1]) && dp_v[m] |-> !m_hready[m]);
    end
  end
endmodule

bind ahb_xbar_route ahb_xbar_route_chk #(
  .NM(NM), .NS(NS), .DW(DW), .SW(SW), .REG_FWD(REG_FWD)
) chk (
  .clk(clk), .rst_n(rst_n), .m_htrans(m_htrans), .m_hready(m_hready),
  .m_hresp(m_hresp), .m_hrdata(m_hrdata), .s_hreadyout(s_hreadyout),
  .dp_v(dp_v), .dp_t(dp_t), .pend(pend)
);

// File: tb/ahb_xbar_route_test.sv
module ahb_xbar_route_test;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 2;
  localparam int NS = 2;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NM-1:0][0:0]    m_tgt    [2];
  logic [NM-1:0][1:0]    m_htrans [2];
  logic [NM-1:0][AW-1:0] m_haddr  [2];
  logic [NM-1:0]         m_hwrite [2];
  logic [NM-1:0][2:0]    m_hsize  [2];
  logic [NM-1:0][DW-1:0] m_hwdata [2];
  logic [NM-1:0]         m_hready [2];
  logic [NM-1:0]         m_hresp  [2];
  logic [NM-1:0][DW-1:0] m_hrdata [2];
  logic [NS-1:0][0:0]    s_gnt    [2];
  logic [NS-1:0]         s_gvld   [2];
  logic [NS-1:0]         s_hsel   [2];
  logic [NS-1:0][1:0]    s_htrans [2];
  logic [NS-1:0][AW-1:0] s_haddr  [2];
  logic [NS-1:0]         s_hwrite [2];
  logic [NS-1:0][2:0]    s_hsize  [2];
  logic [NS-1:0][DW-1:0] s_hwdata [2];
  logic [NS-1:0]         s_rdy    [2];
  logic [NS-1:0]         s_rsp    [2];
  logic [NS-1:0][DW-1:0] s_rd     [2];
  logic [DW-1:0]         wlog     [2][NS];
  int                    nacc     [2][NS];

  ahb_xbar_route #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .REG_FWD(1'b0), .CONN(4'b1111)) uut (
    .clk(clk), .rst_n(rst_n), .m_tgt(m_tgt[0]), .m_htrans(m_htrans[0]), .m_haddr(m_haddr[0]),
    .m_hwrite(m_hwrite[0]), .m_hsize(m_hsize[0]), .m_hwdata(m_hwdata[0]),
    .m_hready(m_hready[0]), .m_hresp(m_hresp[0]), .m_hrdata(m_hrdata[0]),
    .s_gnt(s_gnt[0]), .s_gnt_vld(s_gvld[0]), .s_hsel(s_hsel[0]), .s_htrans(s_htrans[0]),
    .s_haddr(s_haddr[0]), .s_hwrite(s_hwrite[0]), .s_hsize(s_hsize[0]), .s_hwdata(s_hwdata[0]),
    .s_hreadyout(s_rdy[0]), .s_hresp(s_rsp[0]), .s_hrdata(s_rd[0]));

  ahb_xbar_route #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .REG_FWD(1'b1), .CONN(4'b0111)) uut_r (
    .clk(clk), .rst_n(rst_n), .m_tgt(m_tgt[1]), .m_htrans(m_htrans[1]), .m_haddr(m_haddr[1]),
    .m_hwrite(m_hwrite[1]), .m_hsize(m_hsize[1]), .m_hwdata(m_hwdata[1]),
    .m_hready(m_hready[1]), .m_hresp(m_hresp[1]), .m_hrdata(m_hrdata[1]),
    .s_gnt(s_gnt[1]), .s_gnt_vld(s_gvld[1]), .s_hsel(s_hsel[1]), .s_htrans(s_htrans[1]),
    .s_haddr(s_haddr[1]), .s_hwrite(s_hwrite[1]), .s_hsize(s_hsize[1]), .s_hwdata(s_hwdata[1]),
    .s_hreadyout(s_rdy[1]), .s_hresp(s_rsp[1]), .s_hrdata(s_rd[1]));

  function automatic logic [DW-1:0] rd_of(int s, logic [AW-1:0] a);
    return 32'h5A00_0000 | (DW'(s) << 16) | DW'(a[15:0]);
  endfunction

  function automatic int wait_of(logic [AW-1:0] a);
    return int'((a >> 2) % 3);
  endfunction

  for (genvar i = 0; i < 2; i++) begin : g_i
    for (genvar s = 0; s < NS; s++) begin : g_s
      logic busy, wr;
      logic [1:0] cnt;
      logic [AW-1:0] a;
      logic [DW-1:0] lw;
      int na;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          busy <= 1'b0; wr <= 1'b0; cnt <= '0; a <= '0; lw <= '0; na <= 0;
        end else if (busy && cnt != 0) begin
          cnt <= cnt - 2'd1;
        end else begin
          if (busy && wr) lw <= s_hwdata[i][s];
          busy <= s_hsel[i][s] && s_htrans[i][s][1];
          if (s_hsel[i][s] && s_htrans[i][s][1]) begin
            cnt <= 2'(wait_of(s_haddr[i][s]));
            wr  <= s_hwrite[i][s];
            a   <= s_haddr[i][s];
            na  <= na + 1;
          end
        end
      end
      assign s_rdy[i][s] = !(busy && cnt != 0);
      assign s_rsp[i][s] = busy && cnt == 0 && a[7:0] == 8'hEE;
      assign s_rd[i][s]  = (busy && cnt == 0 && !wr) ? rd_of(s, a) : '0;
      assign wlog[i][s]  = lw;
      assign nacc[i][s]  = na;
    end
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(int i, int m, int s, logic [AW-1:0] addr, bit wr, logic [DW-1:0] wd, bit conn);
    int cyc, exp_c, na0;
    logic [DW-1:0] rd;
    logic rsp;
    na0 = nacc[i][s];
    @(negedge clk);
    m_tgt[i][m] = 1'(s); m_htrans[i][m] = 2'b10; m_haddr[i][m] = addr;
    m_hwrite[i][m] = wr; m_hsize[i][m] = 3'd2;
    s_gnt[i][s] = 1'(m); s_gvld[i][s] = 1'b1;
    #1;
    if (i == 0) begin
      check("R1 R5 hsel same cycle", DW'(s_hsel[i][s]), 1);
      check("R1 addr forwarded", s_haddr[i][s], addr);
      check("R1 direction forwarded", DW'(s_hwrite[i][s]), DW'(wr));
    end
    @(negedge clk);
    m_htrans[i][m] = 2'b00; s_gvld[i][s] = 1'b0; m_hwdata[i][m] = wd;
    m_tgt[i][m] = 1'(s ^ 1);
    #1;
    if (i == 1 && conn) begin
      check("R6 hsel one cycle later", DW'(s_hsel[i][s]), 1);
      check("R6 R1 addr forwarded", s_haddr[i][s], addr);
    end
    if (i == 1 && !conn) check("R8 cut path not forwarded", DW'(s_hsel[i][s]), 0);
    cyc = 1;
    while (!m_hready[i][m]) begin
      @(negedge clk); #1; cyc++;
    end
    rd = m_hrdata[i][m];
    rsp = m_hresp[i][m];
    exp_c = conn ? wait_of(addr) + 1 + i : 1;
    check(i == 0 ? "R5 data-phase length" : (conn ? "R6 data-phase length" : "R9 cut path ready"),
          DW'(cyc), DW'(exp_c));
    check(conn ? "R4 R3 read data to issuer" : "R9 cut path zero data", rd,
          (conn && !wr) ? rd_of(s, addr) : '0);
    check(conn ? "R4 response routed" : "R9 cut path OKAY", DW'(rsp),
          DW'(conn && addr[7:0] == 8'hEE));
    if (wr && conn) begin
      @(negedge clk); #1;
      check("R2 write data at subordinate", wlog[i][s], wd);
    end
    check(conn ? "R1 one access" : "R8 no access", DW'(nacc[i][s] - na0), DW'(conn));
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_tgt[i] = '0; m_htrans[i] = '0; m_haddr[i] = '0; m_hwrite[i] = '0;
      m_hsize[i] = '0; m_hwdata[i] = '0; s_gnt[i] = '0; s_gvld[i] = '0;
    end
    repeat (3) @(negedge clk);
    #1;
    for (int i = 0; i < 2; i++) begin
      check("R10 reset ready", DW'(m_hready[i]), DW'(2'b11));
      check("R10 reset resp", DW'(m_hresp[i]), 0);
      check("R10 reset rdata", m_hrdata[i][0] | m_hrdata[i][1], 0);
      check("R10 reset hsel", DW'(s_hsel[i]), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 2; i++)
      for (int m = 0; m < NM; m++)
        for (int s = 0; s < NS; s++)
          for (int k = 0; k < 6; k++) begin
            logic [AW-1:0] ad;
            bit c;
            ad = AW'(k * 4 + s * 32'h100 + m * 32'h40);
            c = !(i == 1 && m == 1 && s == 1);
            xfer(i, m, s, ad, 1'b0, '0, c);
            xfer(i, m, s, ad, 1'b1, 32'hC0DE_0000 | DW'(ad), c);
          end
    for (int i = 0; i < 2; i++) begin
      xfer(i, 0, 1, 32'h0000_12EE, 1'b0, '0, 1'b1);
      xfer(i, 1, 0, 32'h0000_34EE, 1'b0, '0, 1'b1);
    end
    for (int k = 0; k < 6; k++) begin
      fork
        xfer(0, 0, 0, AW'(32'h200 + k * 4), 1'b0, '0, 1'b1);
        xfer(0, 1, 1, AW'(32'h300 + k * 8), 1'b0, '0, 1'b1);
      join
      fork
        xfer(0, 0, 1, AW'(32'h400 + k * 4), 1'b1, DW'(32'hAAAA_0000 + k), 1'b1);
        xfer(0, 1, 0, AW'(32'h500 + k * 8), 1'b1, DW'(32'h5555_0000 + k), 1'b1);
      join
      fork
        xfer(1, 0, 1, AW'(32'h600 + k * 4), 1'b0, '0, 1'b1);
        xfer(1, 1, 0, AW'(32'h700 + k * 8), 1'b0, '0, 1'b1);
      join
    end
    $display("R7 concurrent pairs covered by the forked transfers above");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule